// File: doc/BRIEF.md
# Splittable Performance Counter Bank

This block is a bank of event counters on a 64-bit register bus. Each physical counter runs either as one 32-bit counter or as two 16-bit halves. The halves count separately, and each half is addressed as its own logical counter. A per-counter size bit in the global control word picks the mode.

Software writes to a counter do not reach the running count at once. They are held in a per-counter holding latch until the control word is written with the enable bit set. That write also commits pending values when the unit is already running, even if the written value does not change. A status register records wrap events, one bit per logical counter. Reading it clears the bits, writing it sets the interrupt enable mask, and the interrupt output is raised while any enabled bit is pending. Each logical counter also has a plain 32-bit control register for use elsewhere.

Top module: `perf_ctr_bank`

## Requirements
- R1: After a synchronous active-high reset, all counters, latches, control registers, status bits and the interrupt mask are zero, and `irq` is low.
- R2: Every register occupies bits 63:32 of the bus. Bits 31:0 of `bus_wdata` are ignored, and bits 31:0 of `bus_rdata` are always zero. Read data appears on `bus_rdata` in the cycle after `bus_rd` and is zero in every cycle that follows no read.
- R3: A counter write stores the value in a holding latch and marks it pending. Reads return the latched value while the write is pending, and the running count is left unchanged.
- R4: A write to the control word (address 0) with bit 0 (enable) set commits every pending latch into its running counter and clears the pending marks. This happens even when the unit is already enabled and the value is unchanged. A control write with enable clear commits nothing.
- R5: Counters advance by one per cycle on their event input only while the enable bit is set. In 32-bit mode, physical counter p counts `evt[p]`.
- R6: Control bit 8+p set puts physical counter p in 16-bit mode. Logical counter p (address 16+p) is then the upper half and counts `evt[p]`. Logical counter N+p (address 16+N+p) is the lower half and counts `evt[N+p]`. No carry passes from the lower half into the upper half.
- R7: In 16-bit mode, a write uses only bits 47:32 of `bus_wdata` and replaces only the addressed half. A read returns that half zero-extended.
- R8: A wrap from all ones to zero sets a status bit. In 16-bit mode the bit is p for the upper half and N+p for the lower half. In 32-bit mode the bit is p.
- R9: Reading the status register (address 1) returns the pending bits in bits 32+2N-1:32 and clears them. Writing it loads the interrupt mask, and writing zero disables all interrupts. `irq` is high while any pending bit has its mask bit set.
- R10: Each logical counter j has a 32-bit control register at address 32+j that reads back the last value written.
- R11: In 32-bit mode, logical counters p and N+p both access the whole 32-bit physical counter p.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 6 | Register word address |
| bus_wdata | input | 64 | Write data; bits 63:32 used |
| bus_rdata | output | 64 | Registered read data |
| evt | input | 2N (8) | Event inputs, one per logical counter |
| irq | output | 1 | Interrupt: any pending bit with its mask bit set |

## Verification
A read returns its data after the next rising edge. The bench samples `bus_rdata` at the falling edge that follows, then drops the strobe. Register writes, commits and mask loads take effect at the edge where the strobe is sampled, so `irq` and counter contents are checked at the falling edge after the write ends. Events are driven on falling edges and held for n rising edges, so the expected counts are exactly n per pulse. Wraps reach the status bits at the same edge as the count.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
    // Which part of a physical counter a bus write targets
    typedef enum logic [1:0] {
        HALF_NONE = 2'd0,
        HALF_FULL = 2'd1,
        HALF_HI   = 2'd2,
        HALF_LO   = 2'd3
    } half_e;
endpackage

// File: rtl/pcb_slice.sv
module pcb_slice
    import pcb_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         split,
    input  logic         ev_hi,
    input  logic         ev_lo,
    input  logic         commit,
    input  half_e        wr_sel,
    input  logic [W-1:0] wr_val,
    output logic [W-1:0] view,
    output logic         pending,
    output logic         wrap_hi,
    output logic         wrap_lo
);
    localparam int H = W / 2;

    typedef struct packed {
        logic [W-1:0] live;
        logic [W-1:0] latch;
        logic         pend;
    } slice_t;

    slice_t s_d, s_q;
    logic [W-1:0] cur;
    logic take, step_hi, step_lo;

    always_comb begin
        s_d     = s_q;
        cur     = s_q.pend ? s_q.latch : s_q.live;
        take    = commit && s_q.pend;
        step_hi = run && ev_hi;
        step_lo = run && ev_lo && split;
        wrap_hi = 1'b0;
        wrap_lo = 1'b0;

        if (take) begin
            s_d.live = s_q.latch;
            s_d.pend = 1'b0;
        end else if (split) begin
            s_d.live[W-1:H] = s_q.live[W-1:H] + H'(step_hi);
            s_d.live[H-1:0] = s_q.live[H-1:0] + H'(step_lo);
            wrap_hi = step_hi && (&s_q.live[W-1:H]);
            wrap_lo = step_lo && (&s_q.live[H-1:0]);
        end else begin
            s_d.live = s_q.live + W'(step_hi);
            wrap_hi  = step_hi && (&s_q.live);
        end

        case (wr_sel)
            HALF_FULL: begin
                s_d.latch = wr_val;
                s_d.pend  = 1'b1;
            end
            HALF_HI: begin
                s_d.latch = {wr_val[H-1:0], cur[H-1:0]};
                s_d.pend  = 1'b1;
            end
            HALF_LO: begin
                s_d.latch = {cur[W-1:H], wr_val[H-1:0]};
                s_d.pend  = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign view    = cur;
    assign pending = s_q.pend;
endmodule

// File: rtl/pcb_status.sv
module pcb_status #(
    parameter int NB = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NB-1:0] set_bits,
    input  logic          clear,
    input  logic          mask_we,
    input  logic [NB-1:0] mask_val,
    output logic [NB-1:0] pend,
    output logic          irq
);
    typedef struct packed {
        logic [NB-1:0] pend;
        logic [NB-1:0] mask;
    } stat_t;

    stat_t t_d, t_q;

    always_comb begin
        t_d      = t_q;
        // a wrap in the same cycle as a clearing read survives
        t_d.pend = (clear ? '0 : t_q.pend) | set_bits;
        if (mask_we) t_d.mask = mask_val;
    end

    always_ff @(posedge clk) begin
        if (rst) t_q <= '0;
        else     t_q <= t_d;
    end

    assign pend = t_q.pend;
    assign irq  = |(t_q.pend & t_q.mask);
endmodule

// File: rtl/perf_ctr_bank.sv
module perf_ctr_bank
    import pcb_pkg::*;
#(
    parameter int N_PHYS    = 4,
    parameter int ADDR_W    = 6,
    parameter int CTRL_ADDR = 0,
    parameter int STAT_ADDR = 1,
    parameter int CNT_BASE  = 16,
    parameter int LCTL_BASE = 32,
    parameter int EN_BIT    = 0,
    parameter int SIZE_LSB  = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [63:0]           bus_wdata,
    output logic [63:0]           bus_rdata,
    input  logic [2*N_PHYS-1:0]   evt,
    output logic                  irq
);
    localparam int NLOG   = 2 * N_PHYS;
    localparam int LOG_W  = $clog2(NLOG);
    localparam int PHYS_W = (N_PHYS > 1) ? $clog2(N_PHYS) : 1;
    localparam int RW     = 32;
    localparam int HW     = RW / 2;
    localparam int BUS_W  = 64;

    typedef struct packed {
        logic                     en;
        logic [N_PHYS-1:0]        size;
        logic [NLOG-1:0][RW-1:0]  lctl;
        logic [BUS_W-1:0]         rdata;
    } top_t;

    top_t st_d, st_q;

    logic [RW-1:0]             wval;
    logic                      in_cnt, in_lctl, is_ctrl, is_stat;
    logic [ADDR_W-1:0]         offc, offl;
    logic [LOG_W-1:0]          lidx, lsel;
    logic [PHYS_W-1:0]         pidx;
    logic                      upper;
    logic                      commit;
    logic [RW-1:0]             ctrl_word;
    logic [RW-1:0]             sel_view, rd_cnt;
    half_e                     wr_sel [N_PHYS];
    logic [N_PHYS-1:0][RW-1:0] view;
    logic [N_PHYS-1:0]         pend_w, wrap_hi, wrap_lo;
    logic [NLOG-1:0]           stat_pend;

    // values brought out for the bound checker
    logic                      run_w;
    logic [N_PHYS*RW-1:0]      view_flat;

    assign wval    = bus_wdata[BUS_W-1:RW];
    assign is_ctrl = (bus_addr == ADDR_W'(CTRL_ADDR));
    assign is_stat = (bus_addr == ADDR_W'(STAT_ADDR));
    assign in_cnt  = (bus_addr >= ADDR_W'(CNT_BASE)) && (bus_addr < ADDR_W'(CNT_BASE + NLOG));
    assign in_lctl = (bus_addr >= ADDR_W'(LCTL_BASE)) && (bus_addr < ADDR_W'(LCTL_BASE + NLOG));
    assign offc    = bus_addr - ADDR_W'(CNT_BASE);
    assign offl    = bus_addr - ADDR_W'(LCTL_BASE);
    assign lidx    = offc[LOG_W-1:0];
    assign lsel    = offl[LOG_W-1:0];
    assign pidx    = lidx[PHYS_W-1:0];
    assign upper   = (lidx < LOG_W'(N_PHYS));
    assign commit  = bus_wr && is_ctrl && wval[EN_BIT];

    always_comb begin
        ctrl_word                       = '0;
        ctrl_word[EN_BIT]               = st_q.en;
        ctrl_word[SIZE_LSB +: N_PHYS]   = st_q.size;

        sel_view = view[pidx];
        if (st_q.size[pidx])
            rd_cnt = upper ? {{HW{1'b0}}, sel_view[RW-1:HW]} : {{HW{1'b0}}, sel_view[HW-1:0]};
        else
            rd_cnt = sel_view;

        for (int p = 0; p < N_PHYS; p++) begin
            if (bus_wr && in_cnt && (pidx == PHYS_W'(p)))
                wr_sel[p] = st_q.size[p] ? (upper ? HALF_HI : HALF_LO) : HALF_FULL;
            else
                wr_sel[p] = HALF_NONE;
        end

        st_d       = st_q;
        st_d.rdata = '0;

        if (bus_wr) begin
            if (is_ctrl) begin
                st_d.en   = wval[EN_BIT];
                st_d.size = wval[SIZE_LSB +: N_PHYS];
            end
            if (in_lctl) st_d.lctl[lsel] = wval;
        end

        if (bus_rd) begin
            if (is_ctrl)      st_d.rdata = {ctrl_word, {RW{1'b0}}};
            else if (is_stat) st_d.rdata = {RW'(stat_pend), {RW{1'b0}}};
            else if (in_cnt)  st_d.rdata = {rd_cnt, {RW{1'b0}}};
            else if (in_lctl) st_d.rdata = {st_q.lctl[lsel], {RW{1'b0}}};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    for (genvar p = 0; p < N_PHYS; p++) begin : g_slice
        pcb_slice #(.W(RW)) u_slice (
            .clk     (clk),
            .rst     (rst),
            .run     (st_q.en),
            .split   (st_q.size[p]),
            .ev_hi   (evt[p]),
            .ev_lo   (evt[N_PHYS + p]),
            .commit  (commit),
            .wr_sel  (wr_sel[p]),
            .wr_val  (wval),
            .view    (view[p]),
            .pending (pend_w[p]),
            .wrap_hi (wrap_hi[p]),
            .wrap_lo (wrap_lo[p])
        );
    end

    pcb_status #(.NB(NLOG)) u_status (
        .clk      (clk),
        .rst      (rst),
        .set_bits ({wrap_lo, wrap_hi}),
        .clear    (bus_rd && is_stat),
        .mask_we  (bus_wr && is_stat),
        .mask_val (wval[NLOG-1:0]),
        .pend     (stat_pend),
        .irq      (irq)
    );

    assign bus_rdata = st_q.rdata;
    assign run_w     = st_q.en;
    assign view_flat = view;
endmodule

// File: rtl/pcb_checker.sv
module pcb_checker #(
    parameter int N_PHYS    = 4,
    parameter int ADDR_W    = 6,
    parameter int CTRL_ADDR = 0,
    parameter int STAT_ADDR = 1,
    parameter int EN_BIT    = 0
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   bus_wr,
    input logic                   bus_rd,
    input logic [ADDR_W-1:0]      bus_addr,
    input logic [63:0]            bus_wdata,
    input logic [63:0]            bus_rdata,
    input logic                   irq,
    input logic                   run_w,
    input logic [N_PHYS-1:0]      pend_w,
    input logic [N_PHYS*32-1:0]   view_flat
);
    // R2: lower half of every read word is zero
    a_r2_low_half_zero: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[31:0] == 32'd0);

    // R2: no read strobe, no read data next cycle
    a_r2_idle_rdata: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> bus_rdata == 64'd0);

    // R3 / R5: stopped unit with no bus write keeps every counter view
    a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        (!run_w && !bus_wr) |=> $stable(view_flat));

    // R4: enabling control write leaves nothing pending
    a_r4_commit_clears: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_W'(CTRL_ADDR) && bus_wdata[32+EN_BIT]) |=> pend_w == '0);

    // R9: clearing read while stopped drops the interrupt
    a_r9_read_clears: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == ADDR_W'(STAT_ADDR) && !run_w && !bus_wr) |=> !irq);

    // R9: zero mask disables the interrupt
    a_r9_mask_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_W'(STAT_ADDR) && bus_wdata[32 +: 2*N_PHYS] == '0) |=> !irq);
endmodule

bind perf_ctr_bank pcb_checker #(
    .N_PHYS    (N_PHYS),
    .ADDR_W    (ADDR_W),
    .CTRL_ADDR (CTRL_ADDR),
    .STAT_ADDR (STAT_ADDR),
    .EN_BIT    (EN_BIT)
) u_pcb_checker (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .run_w     (run_w),
    .pend_w    (pend_w),
    .view_flat (view_flat)
);

// File: tb/test_perf_ctr_bank.sv
`timescale 1ns/1ps
module test_perf_ctr_bank;
    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [63:0] bus_wdata = '0;
    logic [63:0] bus_rdata;
    logic [2*N-1:0] evt = '0;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    logic [63:0] rv;

    always #5 clk = ~clk;

    perf_ctr_bank i_perf_ctr_bank (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt(evt), .irq(irq)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d, input logic [31:0] junk = 32'h0);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = {d, junk};
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [63:0] v);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(posedge clk);
        @(negedge clk);
        bus_rd = 1'b0;
        v = bus_rdata;
    endtask

    task automatic pulse(input logic [2*N-1:0] m, input int n);
        @(negedge clk);
        evt = m;
        repeat (n) @(negedge clk);
        evt = '0;
    endtask

    task automatic t_reset();
        rd(6'd0, rv);  chk("R1 ctrl", rv, 64'h0);
        rd(6'd1, rv);  chk("R1 status", rv, 64'h0);
        rd(6'd16, rv); chk("R1 counter0", rv, 64'h0);
        rd(6'd35, rv); chk("R1 lctl3", rv, 64'h0);
        chk("R1 irq", {63'h0, irq}, 64'h0);
    endtask

    task automatic t_latch();
        wr(6'd16, 32'h1234_5678, 32'hDEAD_BEEF);
        pulse(8'h01, 5);
        rd(6'd16, rv); chk("R2 R3 latched read, low half zero", rv, {32'h1234_5678, 32'h0});
        rd(6'd19, rv); chk("R5 disabled no count", rv, 64'h0);
        wr(6'd0, 32'h1);
        pulse(8'h01, 3);
        rd(6'd16, rv); chk("R5 count after enable", rv, {32'h1234_567B, 32'h0});
        @(negedge clk);
        chk("R2 idle rdata", bus_rdata, 64'h0);
    endtask

    task automatic t_commit();
        wr(6'd17, 32'd100);
        pulse(8'h02, 4);
        rd(6'd17, rv); chk("R3 pending read while running", rv, {32'd100, 32'h0});
        wr(6'd0, 32'h1);
        pulse(8'h02, 2);
        rd(6'd17, rv); chk("R4 rewrite commits", rv, {32'd102, 32'h0});
    endtask

    task automatic t_split();
        wr(6'd0, 32'h0000_0101);
        wr(6'd16, 32'hABCD_FFFE);
        wr(6'd20, 32'h5555_FFFF);
        wr(6'd0, 32'h0000_0101);
        rd(6'd16, rv); chk("R7 upper half write", rv, {32'h0000_FFFE, 32'h0});
        rd(6'd20, rv); chk("R7 lower half write", rv, {32'h0000_FFFF, 32'h0});
        pulse(8'h01, 3);
        pulse(8'h10, 2);
        rd(6'd16, rv); chk("R6 R8 upper wraps, no carry", rv, {32'h0000_0001, 32'h0});
        rd(6'd20, rv); chk("R6 lower half count", rv, {32'h0000_0001, 32'h0});
        chk("R9 irq masked", {63'h0, irq}, 64'h0);
        wr(6'd1, 32'h10);
        chk("R9 irq with mask", {63'h0, irq}, 64'h1);
        rd(6'd1, rv); chk("R8 R9 status bits", rv, {32'h11, 32'h0});
        chk("R9 irq after clear", {63'h0, irq}, 64'h0);
        rd(6'd1, rv); chk("R9 status cleared", rv, 64'h0);
        wr(6'd1, 32'h0);
    endtask

    task automatic t_ovf32();
        wr(6'd0, 32'h1);
        wr(6'd22, 32'hFFFF_FFFE);
        wr(6'd0, 32'h1);
        wr(6'd1, 32'h04);
        pulse(8'h04, 2);
        rd(6'd18, rv); chk("R11 R8 32-bit wrap", rv, 64'h0);
        chk("R9 irq on 32-bit wrap", {63'h0, irq}, 64'h1);
        rd(6'd1, rv); chk("R8 status bit2", rv, {32'h04, 32'h0});
        rd(6'd16, rv); chk("R11 full read", rv, {32'h0001_0001, 32'h0});
        wr(6'd1, 32'h0);
        chk("R9 irq off", {63'h0, irq}, 64'h0);
    endtask

    task automatic t_lctl();
        wr(6'd37, 32'hA5A5_0F0F);
        rd(6'd37, rv); chk("R10 lctl5 readback", rv, {32'hA5A5_0F0F, 32'h0});
        rd(6'd32, rv); chk("R10 lctl0 untouched", rv, 64'h0);
        rd(6'd0, rv);  chk("R4 ctrl readback", rv, {32'h1, 32'h0});
        wr(6'd0, 32'h0);
        pulse(8'h04, 4);
        rd(6'd18, rv); chk("R5 stopped after disable", rv, 64'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_latch();
        t_commit();
        t_split();
        t_ovf32();
        t_lctl();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule